// File: doc/BRIEF.md
# I2S Sample FIFO Front End

This block is the register-side front end of an audio serial port. Software reaches it over a simple single-cycle register bus: a control word, a mode word, a stored prescaler word, a FIFO-control word and a sample data port. Behind the data port sit two 8-entry queues of 16-bit samples, one for playback toward the serializer and one for capture from it. The serializer itself (bit clocking, word select, clock division) lives elsewhere and trades samples with this block through valid/ready handshakes.

Either queue can be switched off, so samples pass directly between the data port and the serializer. Status bits and queue counts are owned by hardware and survive software writes. Two DMA request lines tell a DMA engine when the playback side has room or the capture side has data. After the playback queue runs dry, further draining is held off for a fixed number of cycles.

Top module: `i2s_fifo_front`

## Requirements
- R1: After reset all queue counts, control bits, the bypass sample, both DMA requests, `tx_valid` and `rx_ready` are zero.
- R2: Word addresses are 0 control, 1 mode, 2 prescaler, 3 FIFO control, 4 data port; mode and prescaler read back the full written word.
- R3: A write to control replaces bits 5:0 and keeps bits 8:6; a write to FIFO control replaces bits 9:8 and keeps bits 7:0 (receive count in 3:0, transmit count in 7:4, receive queue enable bit 8, transmit queue enable bit 9).
- R4: A data-port write has no effect unless control bit 0 and mode bit 7 are set; a data-port read returns zero and changes nothing unless control bit 0 and mode bit 6 are set.
- R5: With the transmit queue enabled, a data-port write stores bits 15:0 only when fewer than 8 samples are held, and sets control bit 7.
- R6: Queued transmit samples leave in write order, one per cycle with `tx_valid` and `tx_ready` both high, and the transmit count drops by one for each.
- R7: When the last queued transmit sample leaves, control bit 7 clears and `tx_valid` stays low for the following 8 cycles even if a new sample is written.
- R8: A write that lands in the same cycle as the last queued sample leaving keeps the count at one, keeps control bit 7 set and starts no holdoff.
- R9: With the receive queue enabled, `rx_ready` is high only while fewer than 8 samples are held; the sample that brings the count to 8 clears control bit 6.
- R10: A data-port read with the receive queue enabled returns and removes the oldest sample and sets control bit 6; with the queue empty it returns zero.
- R11: With the transmit queue disabled, a data-port write is offered directly on `tx_data`/`tx_valid` until accepted, and the transmit count stays zero.
- R12: With the receive queue disabled, a data-port read returns `rx_data` and raises `rx_ready` for that cycle only.
- R13: `tx_dreq` is control bit 5 and (transmit queue disabled or fewer than 8 held); `rx_dreq` is control bit 4 and (receive queue disabled or not empty).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| tx_valid | output | 1 | Playback sample offered to serializer |
| tx_ready | input | 1 | Serializer takes the playback sample |
| tx_data | output | 16 | Playback sample |
| rx_valid | input | 1 | Serializer offers a capture sample |
| rx_ready | output | 1 | Block takes the capture sample |
| rx_data | input | 16 | Capture sample |
| tx_dreq | output | 1 | Playback DMA request |
| rx_dreq | output | 1 | Capture DMA request |

## Verification
The playback queue can be written by software in the very cycle the serializer takes its last entry, so a push and the draining pop coincide. The bench provokes this by raising `tx_ready` on the same clock that carries a data-port write while one sample is queued, then judges that the new sample is offered at once with no holdoff, the count reads one and the busy bit stays set. The plain drain-to-empty case is checked alongside it, where the holdoff must blank `tx_valid` for exactly eight cycles.

// File: rtl/i2s_ff_pkg.sv
package i2s_ff_pkg;
    localparam int REG_AW = 3;

    typedef enum logic [REG_AW-1:0] {
        REG_CTRL = 3'd0,
        REG_MODE = 3'd1,
        REG_PSC  = 3'd2,
        REG_FCTL = 3'd3,
        REG_DATA = 3'd4
    } reg_sel_e;

    localparam int CTRL_EN    = 0;
    localparam int CTRL_RXDMA = 4;
    localparam int CTRL_TXDMA = 5;
    localparam int CTRL_RXRDY = 6;
    localparam int CTRL_TXBSY = 7;
    localparam int CTRL_W     = 9;

    localparam int MODE_RX = 6;
    localparam int MODE_TX = 7;

    localparam int FEN_RX = 0;
    localparam int FEN_TX = 1;
endpackage

// File: rtl/i2s_sample_fifo.sv
module i2s_sample_fifo #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [WIDTH-1:0]             wdata,
    input  logic                         pop,
    output logic [WIDTH-1:0]             head,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [PW-1:0]               wp;
        logic [PW-1:0]               rp;
        logic [CW-1:0]               cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic do_push, do_pop;

    always_comb begin
        st_d    = st_q;
        do_push = push && (st_q.cnt < CW'(DEPTH));
        do_pop  = pop && (st_q.cnt != '0);
        if (do_push) begin
            st_d.mem[st_q.wp] = wdata;
            st_d.wp = (st_q.wp == PW'(DEPTH - 1)) ? '0 : st_q.wp + 1'b1;
        end
        if (do_pop) begin
            st_d.rp = (st_q.rp == PW'(DEPTH - 1)) ? '0 : st_q.rp + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head  = st_q.mem[st_q.rp];
    assign count = st_q.cnt;

    // R5: a queue never holds more than its depth
    p_fifo_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH));
endmodule

// File: rtl/i2s_tx_holdoff.sv
module i2s_tx_holdoff #(
    parameter int HOLD = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int HW = $clog2(HOLD + 1);

    logic [HW-1:0] hold_d, hold_q;

    always_comb begin
        if (start)               hold_d = HW'(HOLD);
        else if (hold_q != '0)   hold_d = hold_q - 1'b1;
        else                     hold_d = hold_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    assign busy = (hold_q != '0);

    // R7: an emptying drain arms the full holdoff window
    p_hold_armed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (busy && hold_q == HW'(HOLD)));
endmodule

// File: rtl/i2s_fifo_front.sv
module i2s_fifo_front
    import i2s_ff_pkg::*;
#(
    parameter int DW    = 32,
    parameter int SW    = 16,
    parameter int DEPTH = 8,
    parameter int HOLD  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [SW-1:0]     tx_data,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic [SW-1:0]     rx_data,
    output logic              tx_dreq,
    output logic              rx_dreq
);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [DW-1:0]     mode;
        logic [DW-1:0]     psc;
        logic [1:0]        fen;
        logic              byp_v;
        logic [SW-1:0]     byp_d;
    } regs_t;

    regs_t r_d, r_q;

    logic [SW-1:0] tx_head, rx_head;
    logic [CW-1:0] tx_cnt, rx_cnt;
    logic en_tx, en_rx, tx_fifo_on, rx_fifo_on, dp_wr, dp_rd;
    logic tx_push, tx_pop, rx_push, rx_pop, drained, hold_busy, tx_fire;

    always_comb begin
        en_tx      = r_q.ctrl[CTRL_EN] && r_q.mode[MODE_TX];
        en_rx      = r_q.ctrl[CTRL_EN] && r_q.mode[MODE_RX];
        tx_fifo_on = r_q.fen[FEN_TX];
        rx_fifo_on = r_q.fen[FEN_RX];
        dp_wr      = bus_wr && (bus_addr == REG_DATA);
        dp_rd      = bus_rd && (bus_addr == REG_DATA);

        tx_push  = dp_wr && en_tx && tx_fifo_on && (tx_cnt < CW'(DEPTH));
        tx_valid = tx_fifo_on ? (en_tx && (tx_cnt != '0) && !hold_busy) : r_q.byp_v;
        tx_data  = tx_fifo_on ? tx_head : r_q.byp_d;
        tx_fire  = tx_valid && tx_ready;
        tx_pop   = tx_fifo_on && tx_fire;
        drained  = tx_pop && (tx_cnt == CW'(1)) && !tx_push;

        rx_ready = rx_fifo_on ? (en_rx && (rx_cnt < CW'(DEPTH))) : (dp_rd && en_rx);
        rx_push  = rx_fifo_on && rx_valid && rx_ready;
        rx_pop   = dp_rd && en_rx && rx_fifo_on && (rx_cnt != '0);

        tx_dreq = r_q.ctrl[CTRL_TXDMA] && (!tx_fifo_on || (tx_cnt < CW'(DEPTH)));
        rx_dreq = r_q.ctrl[CTRL_RXDMA] && (!rx_fifo_on || (rx_cnt != '0));
    end

    always_comb begin
        r_d = r_q;
        if (bus_wr) begin
            case (bus_addr)
                REG_CTRL: r_d.ctrl = {r_q.ctrl[CTRL_W-1:6], bus_wdata[5:0]};
                REG_MODE: r_d.mode = bus_wdata;
                REG_PSC:  r_d.psc  = bus_wdata;
                REG_FCTL: r_d.fen  = bus_wdata[9:8];
                default:  ;
            endcase
        end
        if (tx_push)      r_d.ctrl[CTRL_TXBSY] = 1'b1;
        else if (drained) r_d.ctrl[CTRL_TXBSY] = 1'b0;
        if (rx_pop)
            r_d.ctrl[CTRL_RXRDY] = 1'b1;
        else if (rx_push && (rx_cnt == CW'(DEPTH - 1)))
            r_d.ctrl[CTRL_RXRDY] = 1'b0;
        if (dp_wr && en_tx && !tx_fifo_on) begin
            r_d.byp_v = 1'b1;
            r_d.byp_d = bus_wdata[SW-1:0];
        end else if (!tx_fifo_on && tx_fire) begin
            r_d.byp_v = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            REG_CTRL: bus_rdata = DW'(r_q.ctrl);
            REG_MODE: bus_rdata = r_q.mode;
            REG_PSC:  bus_rdata = r_q.psc;
            REG_FCTL: begin
                bus_rdata[9:8] = r_q.fen;
                bus_rdata[7:4] = 4'(tx_cnt);
                bus_rdata[3:0] = 4'(rx_cnt);
            end
            REG_DATA: begin
                if (rx_pop)
                    bus_rdata = DW'(rx_head);
                else if (dp_rd && en_rx && !rx_fifo_on && rx_valid)
                    bus_rdata = DW'(rx_data);
            end
            default: bus_rdata = '0;
        endcase
    end

    i2s_sample_fifo #(.WIDTH(SW), .DEPTH(DEPTH)) u_tx_fifo (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .wdata(bus_wdata[SW-1:0]),
        .pop(tx_pop), .head(tx_head), .count(tx_cnt)
    );

    i2s_sample_fifo #(.WIDTH(SW), .DEPTH(DEPTH)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_data),
        .pop(rx_pop), .head(rx_head), .count(rx_cnt)
    );

    i2s_tx_holdoff #(.HOLD(HOLD)) u_holdoff (
        .clk(clk), .rst_n(rst_n), .start(drained), .busy(hold_busy)
    );

    // R5: an accepted playback write marks the transmit side busy
    p_push_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_push |=> r_q.ctrl[CTRL_TXBSY]);

    // R9: a full capture queue refuses the serializer
    p_rx_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_fifo_on && rx_cnt == CW'(DEPTH)) |-> !rx_ready);

    // R10: removing a capture sample flags data ready to software
    p_pop_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |=> r_q.ctrl[CTRL_RXRDY]);

    // R8: a push alongside the last drain leaves exactly one sample
    p_overlap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_push && tx_pop && tx_cnt == CW'(1)) |=> (tx_cnt == CW'(1) && !hold_busy));
endmodule

// File: tb/test_i2s_fifo_front.sv
module test_i2s_fifo_front;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        tx_valid, tx_ready = 1'b0;
    logic [15:0] tx_data;
    logic        rx_valid = 1'b0, rx_ready;
    logic [15:0] rx_data = '0;
    logic        tx_dreq, rx_dreq;

    int n_chk = 0, n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2s_fifo_front i_i2s_fifo_front (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
        .tx_dreq(tx_dreq), .rx_dreq(rx_dreq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 tx_valid", 32'(tx_valid), 0);
        chk("R1 rx_ready", 32'(rx_ready), 0);
        chk("R1 tx_dreq", 32'(tx_dreq), 0);
        chk("R1 rx_dreq", 32'(rx_dreq), 0);
        rd(3'd0, v); chk("R1 ctrl", v, 0);
        rd(3'd3, v); chk("R1 fifo ctrl", v, 0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        wr(3'd1, 32'hA5A5_00C0); rd(3'd1, v); chk("R2 mode readback", v, 32'hA5A5_00C0);
        wr(3'd2, 32'h0001_1234); rd(3'd2, v); chk("R2 prescaler readback", v, 32'h0001_1234);
        wr(3'd0, 32'h0000_01C1); rd(3'd0, v); chk("R3 ctrl hw bits kept", v, 32'h001);
        wr(3'd3, 32'h0000_03FF); rd(3'd3, v); chk("R3 fifo ctrl counts kept", v, 32'h300);
    endtask

    task automatic t_gate();
        logic [31:0] v;
        wr(3'd1, 32'h0);
        wr(3'd4, 32'h0055);
        rd(3'd3, v); chk("R4 write ignored when tx off", v, 32'h300);
        rx_valid = 1'b1; rx_data = 16'h1111;
        #1 chk("R4 no capture when rx off", 32'(rx_ready), 0);
        rd(3'd4, v); chk("R4 read returns zero", v, 0);
        rx_valid = 1'b0;
        rd(3'd3, v); chk("R4 read changed nothing", v, 32'h300);
        wr(3'd1, 32'h0000_00C0);
    endtask

    task automatic t_tx_fill();
        logic [31:0] v;
        tx_ready = 1'b0;
        for (int i = 0; i < 9; i++) wr(3'd4, 32'h1000 + i);
        rd(3'd3, v); chk("R5 count capped at 8", v, 32'h380);
        rd(3'd0, v); chk("R5 busy bit set", v, 32'h081);
        wr(3'd0, 32'h001);
        rd(3'd0, v); chk("R3 busy bit kept over write", v, 32'h081);
        tx_ready = 1'b1;
        for (int i = 0; i < 8; i++) begin
            chk("R6 tx_valid while draining", 32'(tx_valid), 1);
            chk("R6 drain order", 32'(tx_data), 32'h1000 + i);
            @(negedge clk);
        end
        tx_ready = 1'b0;
        rd(3'd3, v); chk("R6 count back to zero", v, 32'h300);
        rd(3'd0, v); chk("R7 busy bit cleared on empty", v, 32'h001);
        idle(12);
    endtask

    task automatic t_hold();
        tx_ready = 1'b0;
        wr(3'd4, 32'h0000_00AA);
        chk("R7 offer before drain", 32'(tx_valid), 1);
        tx_ready = 1'b1;
        @(negedge clk);
        wr(3'd4, 32'h0000_00BB);
        for (int k = 2; k <= 8; k++) begin
            chk("R7 holdoff blanks tx_valid", 32'(tx_valid), 0);
            @(negedge clk);
        end
        chk("R7 offer after holdoff", 32'(tx_valid), 1);
        chk("R7 sample after holdoff", 32'(tx_data), 32'h00BB);
        @(negedge clk);
        tx_ready = 1'b0;
        idle(12);
    endtask

    task automatic t_overlap();
        logic [31:0] v;
        tx_ready = 1'b0;
        wr(3'd4, 32'h0000_0C01);
        tx_ready = 1'b1;
        wr(3'd4, 32'h0000_0C02);
        tx_ready = 1'b0;
        chk("R8 no holdoff after overlap", 32'(tx_valid), 1);
        chk("R8 new sample offered", 32'(tx_data), 32'h0C02);
        rd(3'd3, v); chk("R8 count stays one", v, 32'h310);
        rd(3'd0, v); chk("R8 busy bit stays set", v, 32'h081);
        tx_ready = 1'b1; @(negedge clk); tx_ready = 1'b0;
        idle(12);
    endtask

    task automatic t_rx();
        logic [31:0] v;
        rd(3'd4, v); chk("R10 empty read returns zero", v, 0);
        for (int i = 0; i < 10; i++) begin
            rx_valid = 1'b1; rx_data = 16'(32'h200 + i);
            if (i == 8) chk("R9 rx_ready low when full", 32'(rx_ready), 0);
            @(negedge clk);
        end
        rx_valid = 1'b0;
        rd(3'd3, v); chk("R9 count stops at 8", v, 32'h308);
        rd(3'd0, v); chk("R9 ready bit clear when full", v, 32'h001);
        rd(3'd4, v); chk("R10 oldest first", v, 32'h200);
        rd(3'd0, v); chk("R10 pop sets ready bit", v, 32'h041);
        rx_valid = 1'b1; rx_data = 16'h02FF;
        @(negedge clk);
        rx_valid = 1'b0;
        rd(3'd0, v); chk("R9 refill to 8 clears ready bit", v, 32'h001);
        for (int i = 1; i < 8; i++) begin
            rd(3'd4, v); chk("R10 pop order", v, 32'h200 + i);
        end
        rd(3'd4, v); chk("R10 last sample", v, 32'h2FF);
        rd(3'd4, v); chk("R10 read of empty queue", v, 0);
    endtask

    task automatic t_dma();
        logic [31:0] v;
        wr(3'd0, 32'h031);
        chk("R13 tx_dreq with room", 32'(tx_dreq), 1);
        chk("R13 rx_dreq when empty", 32'(rx_dreq), 0);
        rx_valid = 1'b1; rx_data = 16'h0D0D; @(negedge clk); rx_valid = 1'b0;
        chk("R13 rx_dreq with data", 32'(rx_dreq), 1);
        rd(3'd4, v);
        tx_ready = 1'b0;
        for (int i = 0; i < 8; i++) wr(3'd4, 32'h0E00 + i);
        chk("R13 tx_dreq when full", 32'(tx_dreq), 0);
        tx_ready = 1'b1; idle(8); tx_ready = 1'b0;
        chk("R13 tx_dreq after drain", 32'(tx_dreq), 1);
        wr(3'd3, 32'h000);
        chk("R13 tx_dreq with queue off", 32'(tx_dreq), 1);
        chk("R13 rx_dreq with queue off", 32'(rx_dreq), 1);
        wr(3'd0, 32'h001);
        chk("R13 tx_dreq masked", 32'(tx_dreq), 0);
        chk("R13 rx_dreq masked", 32'(rx_dreq), 0);
    endtask

    task automatic t_bypass();
        logic [31:0] v;
        tx_ready = 1'b0;
        wr(3'd4, 32'h0000_BEEF);
        chk("R11 bypass offered", 32'(tx_valid), 1);
        chk("R11 bypass data", 32'(tx_data), 32'hBEEF);
        rd(3'd3, v); chk("R11 count stays zero", v, 0);
        chk("R11 offer held until taken", 32'(tx_valid), 1);
        tx_ready = 1'b1; @(negedge clk); tx_ready = 1'b0;
        chk("R11 offer dropped when taken", 32'(tx_valid), 0);
        rx_valid = 1'b1; rx_data = 16'hCAFE;
        #1 chk("R12 rx_ready low without read", 32'(rx_ready), 0);
        bus_addr = 3'd4; bus_rd = 1'b1;
        #1 chk("R12 rx_ready during read", 32'(rx_ready), 1);
        chk("R12 direct sample", bus_rdata, 32'hCAFE);
        @(negedge clk);
        bus_rd = 1'b0; rx_valid = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_gate();
        t_tx_fill();
        t_hold();
        t_overlap();
        t_rx();
        t_dma();
        t_bypass();
        idle(2);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule